// File: doc/BRIEF.md
# Accumulator Fetch-Execute Sequencer

This block is the control and datapath core of a small single-accumulator processor. It keeps a program counter, a memory address register, a memory data register, a current instruction register, an accumulator, a two-bit status register and a stack pointer. It walks each instruction through fetch, decode and execute, one register transfer per clock state. It reaches memory only through its address and data registers: the address pins always show the address register and the write-data pins always show the data register.

The memory is an external synchronous single-port model. Read data for the address shown in one cycle is expected on `mem_rdata` in the next cycle. The latency is fixed, so the memory port has no valid/ready pair and no back-pressure: the sequencer never stalls and the memory must answer every cycle. The interrupt pins are plain level controls. A pending interrupt is looked at only once an instruction has finished its execute phase. Taking it pushes the next-instruction address, the accumulator and the status onto a downward-growing stack. The program counter is then loaded from `irq_vector`. A return-from-interrupt instruction pops the three values in the opposite order.

Top module: `acc_seq_core`

## Requirements
- R1: Fetch takes five states, in this order: the address register takes PC; a wait state covers the one-cycle read latency; the data register takes the read word; PC increments by one; the instruction register takes the data register. Decode takes one state. A load or add takes 9 states in total, a store 8 and a no-op 6.
- R2: An instruction word is 16 bits. Bits [15:12] are the opcode and bits [11:0] are a memory address. The opcodes are 0x1 load, 0x2 add, 0x3 store, 0x4 return-from-interrupt and 0x0 no-op.
- R3: Load reads the addressed word through the data register and places it in the accumulator.
- R4: Add sums the addressed word into the accumulator modulo 2^16. Status bit 0 is set on two's-complement overflow and bit 1 is set when the result's bit 15 is one.
- R5: Store copies the accumulator into the data register and then writes it to the addressed location, with `mem_we` high for exactly one cycle and `mem_wdata` equal to the data register.
- R6: Any opcode other than 0x1 to 0x4 behaves as a no-op: it performs no memory write and changes no register other than the fetch registers.
- R7: A pending interrupt is sampled only at the end of an instruction, and only while interrupts are enabled. Interrupts are enabled at reset.
- R8: Interrupt entry writes PC, then the accumulator, then the status (zero-extended) to addresses 0xFFF, 0xFFE and 0xFFD. The stack pointer decrements after each write. PC then takes `irq_vector`, `irq_ack` pulses for one cycle and interrupts are disabled.
- R9: Return-from-interrupt pops the status, then the accumulator, then PC. Each pop increments the stack pointer first and then reads. Interrupts are enabled again once PC is restored.
- R10: During reset `mem_we` and `irq_ack` are low and `mem_addr` is 0. After reset, fetch starts at address 0 with the stack pointer at 0xFFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_addr | output | 12 | Memory address, always the address register |
| mem_wdata | output | 16 | Memory write data, always the data register |
| mem_we | output | 1 | Memory write strobe |
| mem_rdata | input | 16 | Read data, one cycle after the address |
| irq_pend | input | 1 | Level-sensitive interrupt request |
| irq_vector | input | 12 | Start address of the interrupt routine |
| irq_ack | output | 1 | One-cycle pulse when the vector is taken |

## Verification
Every result of this block lands in memory, so the bench reads its expected values out of its memory model. The first stack write after a load and an add is due in cycle 19 counted from reset release (9 + 9 states, then one set-up state). The bench records the cycle of the first strobe and compares it with 19. Stack contents are copied at the `irq_ack` cycle, which follows the last push. Store results and the no-op guard word are read only after a fixed settling window that follows the second acknowledge. Together these pin down when a result is due as well as what its value is.

// File: rtl/acc_seq_pkg.sv
package acc_seq_pkg;

  localparam int OPC_W = 4;

  localparam logic [OPC_W-1:0] OPC_NOP   = 4'h0;
  localparam logic [OPC_W-1:0] OPC_LOAD  = 4'h1;
  localparam logic [OPC_W-1:0] OPC_ADD   = 4'h2;
  localparam logic [OPC_W-1:0] OPC_STORE = 4'h3;
  localparam logic [OPC_W-1:0] OPC_RETI  = 4'h4;

  // three stacked items: slot 0/1/2
  localparam int STACK_ITEMS = 3;
  localparam int SLOT_W      = 2;

  typedef enum logic [4:0] {
    ST_F_MAR,   // address register <- PC
    ST_F_WAIT,  // memory read in flight
    ST_F_MDR,   // data register <- read word
    ST_F_PC,    // PC <- PC + 1
    ST_F_CIR,   // instruction register <- data register
    ST_DEC,     // decode, address register <- operand
    ST_X_WAIT,
    ST_X_MDR,
    ST_X_ACC,
    ST_X_SMDR,
    ST_X_SWR,
    ST_P_SET,   // address register <- SP, data register <- item
    ST_P_WR,    // write, SP - 1
    ST_VEC,     // PC <- vector, disable
    ST_R_SET,   // SP + 1, address register <- SP + 1
    ST_R_WAIT,
    ST_R_MDR,
    ST_R_LD
  } seq_state_e;

  typedef struct packed {
    logic neg;  // bit 1
    logic ovf;  // bit 0
  } acc_flags_t;

endpackage

// File: rtl/acc_seq_alu.sv
module acc_seq_alu
  import acc_seq_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              do_add,
  input  logic [DATA_W-1:0] acc_in,
  input  logic [DATA_W-1:0] mem_in,
  output logic [DATA_W-1:0] result,
  output acc_flags_t        flags
);

  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] sum;

  always_comb begin
    sum       = acc_in + mem_in;
    result    = do_add ? sum : mem_in;
    flags.neg = result[MSB];
    flags.ovf = do_add && (acc_in[MSB] == mem_in[MSB]) && (sum[MSB] != acc_in[MSB]);
  end

endmodule

// File: rtl/acc_seq_ctrl.sv
module acc_seq_ctrl
  import acc_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [OPC_W-1:0]  opcode,
  input  logic              irq_pend,
  input  logic              irq_en,
  output seq_state_e        state,
  output logic [SLOT_W-1:0] slot
);

  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(STACK_ITEMS - 1);

  seq_state_e state_d;
  seq_state_e after_instr;
  seq_state_e after_return;
  logic [SLOT_W-1:0] slot_d;

  // interrupt sampling point: only once an instruction is complete
  always_comb begin
    after_instr  = (irq_pend && irq_en) ? ST_P_SET : ST_F_MAR;
    after_return = irq_pend ? ST_P_SET : ST_F_MAR;
  end

  always_comb begin
    state_d = state;
    slot_d  = slot;
    unique case (state)
      ST_F_MAR:  state_d = ST_F_WAIT;
      ST_F_WAIT: state_d = ST_F_MDR;
      ST_F_MDR:  state_d = ST_F_PC;
      ST_F_PC:   state_d = ST_F_CIR;
      ST_F_CIR:  state_d = ST_DEC;
      ST_DEC: begin
        if (opcode == OPC_LOAD || opcode == OPC_ADD) state_d = ST_X_WAIT;
        else if (opcode == OPC_STORE)                state_d = ST_X_SMDR;
        else if (opcode == OPC_RETI)                 state_d = ST_R_SET;
        else                                         state_d = after_instr;
      end
      ST_X_WAIT: state_d = ST_X_MDR;
      ST_X_MDR:  state_d = ST_X_ACC;
      ST_X_ACC:  state_d = after_instr;
      ST_X_SMDR: state_d = ST_X_SWR;
      ST_X_SWR:  state_d = after_instr;
      ST_P_SET:  state_d = ST_P_WR;
      ST_P_WR: begin
        if (slot == LAST_SLOT) begin
          state_d = ST_VEC;
          slot_d  = '0;
        end else begin
          state_d = ST_P_SET;
          slot_d  = slot + 1'b1;
        end
      end
      ST_VEC:    state_d = ST_F_MAR;
      ST_R_SET:  state_d = ST_R_WAIT;
      ST_R_WAIT: state_d = ST_R_MDR;
      ST_R_MDR:  state_d = ST_R_LD;
      ST_R_LD: begin
        if (slot == LAST_SLOT) begin
          state_d = after_return;
          slot_d  = '0;
        end else begin
          state_d = ST_R_SET;
          slot_d  = slot + 1'b1;
        end
      end
      default: state_d = ST_F_MAR;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_F_MAR;
      slot  <= '0;
    end else begin
      state <= state_d;
      slot  <= slot_d;
    end
  end

  // R7: entry only begins right after an instruction's last state
  a_r7_entry_after_instr: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_P_SET && slot == '0) |->
      ($past(state) == ST_X_ACC || $past(state) == ST_X_SWR ||
       $past(state) == ST_DEC   || $past(state) == ST_R_LD));

  // R8: the vector is taken only after the third push
  a_r8_vector_after_pushes: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_VEC) |-> ($past(state) == ST_P_WR && $past(slot) == LAST_SLOT));

endmodule

// File: rtl/acc_seq_dp.sv
module acc_seq_dp
  import acc_seq_pkg::*;
#(
  parameter int          ADDR_W   = 12,
  parameter logic [11:0] RESET_PC = 12'h000
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  seq_state_e              state,
  input  logic [SLOT_W-1:0]       slot,
  input  logic [ADDR_W+OPC_W-1:0] mem_rdata,
  input  logic [ADDR_W-1:0]       irq_vector,
  output logic [ADDR_W-1:0]       mem_addr,
  output logic [ADDR_W+OPC_W-1:0] mem_wdata,
  output logic                    mem_we,
  output logic                    irq_ack,
  output logic [OPC_W-1:0]        opcode,
  output logic                    irq_en
);

  localparam int DATA_W = ADDR_W + OPC_W;
  localparam logic [ADDR_W-1:0] STACK_TOP = '1;

  logic [ADDR_W-1:0] pc, mar, sp;
  logic [DATA_W-1:0] mdr, cir, acc;
  acc_flags_t        sr;

  logic [DATA_W-1:0] alu_res;
  acc_flags_t        alu_flags;
  logic [DATA_W-1:0] push_word;
  logic [ADDR_W-1:0] sp_up;

  acc_seq_alu #(.DATA_W(DATA_W)) u_alu (
    .do_add (cir[DATA_W-1 -: OPC_W] == OPC_ADD),
    .acc_in (acc),
    .mem_in (mdr),
    .result (alu_res),
    .flags  (alu_flags)
  );

  always_comb begin
    unique case (slot)
      2'd0:    push_word = DATA_W'(pc);
      2'd1:    push_word = acc;
      default: push_word = DATA_W'(sr);
    endcase
    sp_up = sp + 1'b1;
  end

  assign mem_addr  = mar;
  assign mem_wdata = mdr;
  assign mem_we    = (state == ST_X_SWR) || (state == ST_P_WR);
  assign irq_ack   = (state == ST_VEC);
  assign opcode    = cir[DATA_W-1 -: OPC_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc     <= RESET_PC[ADDR_W-1:0];
      mar    <= '0;
      mdr    <= '0;
      cir    <= '0;
      acc    <= '0;
      sr     <= '0;
      sp     <= STACK_TOP;
      irq_en <= 1'b1;
    end else begin
      unique case (state)
        ST_F_MAR:  mar <= pc;
        ST_F_MDR:  mdr <= mem_rdata;
        ST_F_PC:   pc  <= pc + 1'b1;
        ST_F_CIR:  cir <= mdr;
        ST_DEC:    mar <= cir[ADDR_W-1:0];
        ST_X_MDR:  mdr <= mem_rdata;
        ST_X_ACC: begin
          acc <= alu_res;
          sr  <= alu_flags;
        end
        ST_X_SMDR: mdr <= acc;
        ST_P_SET: begin
          mar <= sp;
          mdr <= push_word;
        end
        ST_P_WR:   sp <= sp - 1'b1;
        ST_VEC: begin
          pc     <= irq_vector;
          irq_en <= 1'b0;
        end
        ST_R_SET: begin
          sp  <= sp_up;
          mar <= sp_up;
        end
        ST_R_MDR:  mdr <= mem_rdata;
        ST_R_LD: begin
          unique case (slot)
            2'd0:    sr <= acc_flags_t'(mdr[1:0]);
            2'd1:    acc <= mdr;
            default: begin
              pc     <= mdr[ADDR_W-1:0];
              irq_en <= 1'b1;
            end
          endcase
        end
        default: ;
      endcase
    end
  end

  // R1: the read during the fetch wait state uses the not-yet-incremented PC
  a_r1_fetch_addr_is_pc: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_F_WAIT) |-> (mar == pc));

  // R1: PC advances by exactly one in the increment state
  a_r1_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_F_PC) |=> (pc == $past(pc) + 1'b1));

  // R5: the store write carries the accumulator on the write-data pins
  a_r5_store_carries_acc: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_X_SWR) |-> (mem_wdata == acc && mem_we));

  // R8: each push moves the stack pointer down by one
  a_r8_sp_down: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_P_WR) |=> (sp == $past(sp) - 1'b1));

  // R7: the vector is never taken while interrupts are disabled
  a_r7_enabled_at_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_VEC) |-> irq_en);

  // R9: interrupts come back on once PC is popped
  a_r9_enable_restored: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_R_LD && slot == 2'd2) |=> irq_en);

endmodule

// File: rtl/acc_seq_core.sv
module acc_seq_core
  import acc_seq_pkg::*;
#(
  parameter int          ADDR_W   = 12,
  parameter logic [11:0] RESET_PC = 12'h000
) (
  input  logic                    clk,
  input  logic                    rst_n,
  output logic [ADDR_W-1:0]       mem_addr,
  output logic [ADDR_W+OPC_W-1:0] mem_wdata,
  output logic                    mem_we,
  input  logic [ADDR_W+OPC_W-1:0] mem_rdata,
  input  logic                    irq_pend,
  input  logic [ADDR_W-1:0]       irq_vector,
  output logic                    irq_ack
);

  seq_state_e        state;
  logic [SLOT_W-1:0] slot;
  logic [OPC_W-1:0]  opcode;
  logic              irq_en;

  acc_seq_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .opcode   (opcode),
    .irq_pend (irq_pend),
    .irq_en   (irq_en),
    .state    (state),
    .slot     (slot)
  );

  acc_seq_dp #(.ADDR_W(ADDR_W), .RESET_PC(RESET_PC)) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .state      (state),
    .slot       (slot),
    .mem_rdata  (mem_rdata),
    .irq_vector (irq_vector),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_we     (mem_we),
    .irq_ack    (irq_ack),
    .opcode     (opcode),
    .irq_en     (irq_en)
  );

  // R5: a write strobe never lasts two cycles
  a_r5_single_write: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && state == ST_X_SWR) |=> !mem_we);

endmodule

// File: tb/tb_acc_seq_core.sv
`timescale 1ns/1ps
module tb_acc_seq_core;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] mem_addr;
  logic [15:0] mem_wdata;
  logic        mem_we;
  logic [15:0] mem_rdata;
  logic        irq_pend;
  logic [11:0] irq_vector = 12'h200;
  logic        irq_ack;

  logic [15:0] mem [0:4095];
  int          cyc;
  int          first_we_cyc;
  logic [11:0] first_we_addr;
  int          ack_cnt;
  logic [15:0] snap [0:1][0:2];
  int          n_chk = 0;
  int          n_fail = 0;

  always #2.5 clk = ~clk;

  acc_seq_core dut (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .mem_rdata(mem_rdata), .irq_pend(irq_pend),
    .irq_vector(irq_vector), .irq_ack(irq_ack)
  );

  // memory model (one-cycle read latency) and interrupt source
  always @(posedge clk) begin
    if (!rst_n) begin
      cyc          <= 0;
      irq_pend     <= 1'b0;
      ack_cnt      <= 0;
      first_we_cyc <= -1;
      mem_rdata    <= '0;
    end else begin
      cyc       <= cyc + 1;
      mem_rdata <= mem[mem_addr];
      if (mem_we) begin
        mem[mem_addr] <= mem_wdata;
        if (first_we_cyc < 0) begin
          first_we_cyc  <= cyc;
          first_we_addr <= mem_addr;
        end
      end
      if (!mem_we && (mem_addr == 12'h101 || mem_addr == 12'h102)) irq_pend <= 1'b1;
      if (irq_ack) begin
        irq_pend <= 1'b0;
        if (ack_cnt < 2) begin
          snap[ack_cnt][0] <= mem[12'hFFF];
          snap[ack_cnt][1] <= mem[12'hFFE];
          snap[ack_cnt][2] <= mem[12'hFFD];
        end
        ack_cnt <= ack_cnt + 1;
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic run_case(input logic [15:0] a, input logic [15:0] b);
    logic [15:0] sum;
    logic [15:0] sr_exp;
    logic        v;
    int          t;
    rst_n = 1'b0;
    for (int i = 0; i < 4096; i++) mem[i] = 16'h0000;
    mem[12'h000] = 16'h1100;  // load 0x100
    mem[12'h001] = 16'h2101;  // add 0x101
    mem[12'h002] = 16'h3102;  // store 0x102
    mem[12'h003] = 16'hF123;  // undefined opcode
    mem[12'h100] = a;
    mem[12'h101] = b;
    mem[12'h104] = ~a ^ 16'h5A5A;
    mem[12'h123] = 16'hDEAD;
    mem[12'h200] = 16'h1104;  // routine: load 0x104
    mem[12'h201] = 16'h3106;  //          store 0x106
    mem[12'h202] = 16'h4000;  //          return
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(mem_we == 1'b0, "R10", "reset mem_we", int'(mem_we), 0);
    check(irq_ack == 1'b0, "R10", "reset irq_ack", int'(irq_ack), 0);
    check(mem_addr == 12'h000, "R10", "reset mem_addr", int'(mem_addr), 0);
    rst_n = 1'b1;
    t = 0;
    while (ack_cnt < 2 && t < 3000) begin
      @(negedge clk);
      t++;
    end
    check(t < 3000, "R8", "two entries seen", ack_cnt, 2);
    repeat (80) @(negedge clk);

    sum    = a + b;
    v      = (a[15] == b[15]) && (sum[15] != a[15]);
    sr_exp = {14'b0, sum[15], v};

    check(first_we_cyc == 19, "R1", "first write cycle", first_we_cyc, 19);
    check(first_we_addr == 12'hFFF, "R8", "first push addr", int'(first_we_addr), 'hFFF);
    check(snap[0][0] == 16'h0002, "R8", "pushed PC", int'(snap[0][0]), 2);
    check(snap[0][1] == sum, "R7", "acc at entry after add", int'(snap[0][1]), int'(sum));
    check(snap[0][2] == sr_exp, "R4", "status after add", int'(snap[0][2]), int'(sr_exp));
    check(mem[12'h102] == sum, "R5", "stored acc", int'(mem[12'h102]), int'(sum));
    check(mem[12'h106] == mem[12'h104], "R3", "load in routine", int'(mem[12'h106]), int'(mem[12'h104]));
    check(snap[1][0] == 16'h0003, "R9", "PC after return", int'(snap[1][0]), 3);
    check(snap[1][1] == sum, "R9", "acc restored", int'(snap[1][1]), int'(sum));
    check(snap[1][2] == sr_exp, "R9", "status restored", int'(snap[1][2]), int'(sr_exp));
    check(mem[12'h123] == 16'hDEAD, "R6", "undefined opcode no write", int'(mem[12'h123]), 'hDEAD);
    check(ack_cnt == 2, "R2", "opcode decode flow", ack_cnt, 2);
  endtask

  logic [15:0] vals [0:7] = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000,
                              16'hFFFF, 16'h4000, 16'hC000, 16'h1234};

  initial begin
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 8; j++)
        run_case(vals[i], vals[j]);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 5);
    n_chk++;
    n_fail++;
    $display("FAIL R1 watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule